// File: doc/BRIEF.md
# Streaming Checksum Accumulator

This block keeps a running arithmetic checksum over a stream of input words. Each word arrives with a qualifying strobe. The block widens the word to the checksum width and adds it to an internal accumulator. A run-time mode input selects how the word is widened. In signed mode the word's top bit is copied into the upper bits (sign extension). In unsigned mode the upper bits are filled with zero. The sum wraps at the checksum width. The input word width and the checksum width are separate parameters.

The handshake uses four signals. A strobe accepts a word. A clear input restarts the sum between messages. A request input asks for the result. A valid output shows when the requested result is on the output. The result is captured from the accumulator's next value, so a word strobed in the same cycle as the request is included in it. The block sits beside a packet encoder or decoder, where it builds or checks a message checksum.

Top module: `cksum_stream_acc`

## Requirements
- R1: After reset, `sum_out_valid` is 0 and `sum_out` is 0.
- R2: With `signed_mode`=0, each accepted word is zero-extended to OUT_W bits before it is added.
- R3: With `signed_mode`=1, each accepted word is sign-extended to OUT_W bits before it is added. Bit IN_W-1 of the word is the sign bit.
- R4: A word on `in_word` is added only in a cycle where `in_valid` is 1. Words presented while `in_valid` is 0 leave the sum unchanged.
- R5: `sum_out_valid` is 1 in the clock after a cycle with `sum_req`=1. `sum_out` then equals the sum of all words accepted since the last clear or reset, up to and including that cycle. `sum_out_valid` never rises without a request in the previous cycle.
- R6: The sum wraps modulo 2^OUT_W.
- R7: `clear_sum`=1 with `in_valid`=0 sets the sum to 0. A request in that cycle or later, with no words in between, returns 0.
- R8: `clear_sum`=1 together with `in_valid`=1 restarts the sum with that cycle's word alone.
- R9: While neither `sum_req`, `in_valid` nor `clear_sum` is high, `sum_out_valid` and `sum_out` keep their values. A cycle with `in_valid` or `clear_sum` high and `sum_req` low makes `sum_out_valid` 0 in the next clock.
- R10: When `sum_req` and `in_valid` are high in the same cycle, the presented result includes that cycle's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies `in_word` for accumulation |
| in_word | input | IN_W | Input data word |
| signed_mode | input | 1 | 1: sign-extend words, 0: zero-extend words |
| clear_sum | input | 1 | Restarts the running sum |
| sum_req | input | 1 | Requests the current checksum |
| sum_out | output | OUT_W | Presented checksum |
| sum_out_valid | output | 1 | Marks `sum_out` as the answer to the last request |

## Verification
The bench feeds words whose top bit is set, such as 0xFF and 0x80. A design that extends them the wrong way produces a different upper byte in signed mode than in unsigned mode. A long run of 0xFF words forces the sum past 2^OUT_W; a design that saturates, or keeps a wider sum, gives a result other than the wrapped value. The bench drives clear and a data word in the same cycle, and a request and a data word in the same cycle. These cases catch a design that gives clear priority and drops the word, or that captures the sum from before the word was added. Idle stretches check that the valid flag is held. A word or a clear after a request must make it drop, which exposes a sticky or self-clearing flag.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

  // Accumulator operation for one cycle
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_ZERO = 2'd2,
    ACC_LOAD = 2'd3
  } acc_op_e;

  function automatic acc_op_e decode_op(input logic clr, input logic vld);
    acc_op_e op;
    case ({clr, vld})
      2'b11:   op = ACC_LOAD;
      2'b10:   op = ACC_ZERO;
      2'b01:   op = ACC_ADD;
      default: op = ACC_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/cksum_rst_sync.sv
module cksum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cksum_extend.sv
module cksum_extend #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  word_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] ext_o
);
  generate
    if (OUT_W > IN_W) begin : g_widen
      localparam int PAD_W = OUT_W - IN_W;
      logic fill;
      assign fill  = signed_i & word_i[IN_W-1];
      assign ext_o = {{PAD_W{fill}}, word_i};
    end else begin : g_trunc
      // Checksum no wider than the word: only the low bits count
      assign ext_o = word_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/cksum_accum.sv
module cksum_accum
  import cksum_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_op_e          op_i,
  input  logic [OUT_W-1:0] ext_i,
  output logic [OUT_W-1:0] acc_next_o
);
  logic [OUT_W-1:0] acc_q;
  logic [OUT_W-1:0] base;
  logic [OUT_W-1:0] addend;
  logic [OUT_W-1:0] acc_d;
  logic             acc_en;

  // One adder: the operand muxes select clear, load and accumulate
  always_comb begin
    base   = (op_i == ACC_ZERO || op_i == ACC_LOAD) ? '0 : acc_q;
    addend = (op_i == ACC_ADD  || op_i == ACC_LOAD) ? ext_i : '0;
    acc_d  = base + addend;
    acc_en = (op_i != ACC_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_next_o = acc_d;
endmodule

// File: rtl/cksum_result.sv
module cksum_result #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             drop_i,
  input  logic [OUT_W-1:0] acc_next_i,
  output logic [OUT_W-1:0] sum_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] res_q;
  logic             val_q;
  logic             val_d;

  always_comb begin
    if (req_i)       val_d = 1'b1;
    else if (drop_i) val_d = 1'b0;
    else             val_d = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 1'b0;
    else        val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (req_i) res_q <= acc_next_i;
  end

  assign sum_o   = res_q;
  assign valid_o = val_q;
endmodule

// File: rtl/cksum_stream_acc.sv
module cksum_stream_acc
  import cksum_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int OUT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  input  logic             signed_mode,
  input  logic             clear_sum,
  input  logic             sum_req,
  output logic [OUT_W-1:0] sum_out,
  output logic             sum_out_valid
);
  logic             rst_sync_n;
  logic [OUT_W-1:0] ext_word;
  logic [OUT_W-1:0] acc_next;
  acc_op_e          op;
  logic             drop;

  cksum_rst_sync #(.STAGES(SYNC_STG)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cksum_extend #(.IN_W(IN_W), .OUT_W(OUT_W)) i_extend (
    .word_i   (in_word),
    .signed_i (signed_mode),
    .ext_o    (ext_word)
  );

  always_comb begin
    op   = decode_op(clear_sum, in_valid);
    drop = clear_sum | in_valid;
  end

  cksum_accum #(.OUT_W(OUT_W)) i_accum (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .op_i       (op),
    .ext_i      (ext_word),
    .acc_next_o (acc_next)
  );

  cksum_result #(.OUT_W(OUT_W)) i_result (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_i      (sum_req),
    .drop_i     (drop),
    .acc_next_i (acc_next),
    .sum_o      (sum_out),
    .valid_o    (sum_out_valid)
  );
endmodule

// File: rtl/cksum_stream_acc_chk.sv
module cksum_stream_acc_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             clear_sum,
  input logic             sum_req,
  input logic [OUT_W-1:0] sum_out,
  input logic             sum_out_valid
);
  // R5: request answered in the next clock
  a_r5_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    sum_req |=> sum_out_valid);

  // R5: valid only rises after a request
  a_r5_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_out_valid) |-> $past(sum_req));

  // R9: data or clear without request drops valid
  a_r9_drop_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
    (!sum_req && (in_valid || clear_sum)) |=> !sum_out_valid);

  // R9: idle cycles hold both outputs
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sum_req && !in_valid && !clear_sum) |=> ($stable(sum_out_valid) && $stable(sum_out)));

  // R7: clear with request and no data presents zero
  a_r7_clear_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_sum && !in_valid && sum_req) |=> (sum_out == '0));
endmodule

bind cksum_stream_acc cksum_stream_acc_chk #(.OUT_W(OUT_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .in_valid      (in_valid),
  .clear_sum     (clear_sum),
  .sum_req       (sum_req),
  .sum_out       (sum_out),
  .sum_out_valid (sum_out_valid)
);

// File: tb/test_cksum_stream_acc.sv
`timescale 1ns/1ps
module test_cksum_stream_acc;
  localparam int IN_W  = 8;
  localparam int OUT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [IN_W-1:0]  in_word;
  logic             signed_mode;
  logic             clear_sum;
  logic             sum_req;
  logic [OUT_W-1:0] sum_out;
  logic             sum_out_valid;

  int  n_checks;
  int  n_errors;
  bit  done;
  logic [OUT_W-1:0] model;

  cksum_stream_acc #(.IN_W(IN_W), .OUT_W(OUT_W)) i_cksum_stream_acc (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .signed_mode   (signed_mode),
    .clear_sum     (clear_sum),
    .sum_req       (sum_req),
    .sum_out       (sum_out),
    .sum_out_valid (sum_out_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then return at the next falling edge
  task automatic cyc(input logic v, input logic [IN_W-1:0] w, input logic clr, input logic req);
    in_valid  = v;
    in_word   = w;
    clear_sum = clr;
    sum_req   = req;
    @(negedge clk);
  endtask

  function automatic logic [OUT_W-1:0] widen(input logic [IN_W-1:0] w, input logic sgn);
    logic [OUT_W-1:0] r;
    r = {{(OUT_W-IN_W){1'b0}}, w};
    if (sgn && w[IN_W-1]) r = r | ~((OUT_W)'((1 << IN_W) - 1));
    return r;
  endfunction

  task automatic feed(input logic [IN_W-1:0] w);
    model = model + widen(w, signed_mode);
    cyc(1'b1, w, 1'b0, 1'b0);
  endtask

  task automatic do_clear();
    model = '0;
    cyc(1'b0, '0, 1'b1, 1'b0);
  endtask

  task automatic request(input string tag);
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk({tag, " valid"}, OUT_W'(sum_out_valid), 1);
    chk({tag, " sum"}, sum_out, model);
    cyc(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", OUT_W'(sum_out_valid), 0);
    chk("R1 sum after reset", sum_out, 0);
  endtask

  task automatic t_unsigned();
    signed_mode = 1'b0;
    do_clear();
    feed(8'h10); feed(8'hFF); feed(8'h80);
    request("R2 unsigned");
    chk("R2 unsigned literal", sum_out, 16'h018F);
  endtask

  task automatic t_gaps();
    signed_mode = 1'b0;
    do_clear();
    feed(8'h20);
    cyc(1'b0, 8'hAA, 1'b0, 1'b0);
    cyc(1'b0, 8'h55, 1'b0, 1'b0);
    feed(8'h03);
    request("R4 gaps");
    chk("R4 gaps literal", sum_out, 16'h0023);
  endtask

  task automatic t_signed();
    signed_mode = 1'b1;
    do_clear();
    feed(8'hFF); feed(8'h80); feed(8'h05);
    request("R3 signed");
    chk("R3 signed literal", sum_out, 16'hFF84);
    signed_mode = 1'b0;
  endtask

  task automatic t_wrap();
    signed_mode = 1'b0;
    do_clear();
    for (int i = 0; i < 300; i++) feed(8'hFF);
    request("R6 wrap");
    chk("R6 wrap literal", sum_out, 16'h2AD4);
  endtask

  task automatic t_clear();
    signed_mode = 1'b0;
    feed(8'h44);
    do_clear();
    request("R7 clear");
    chk("R7 clear literal", sum_out, 16'h0000);
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R9 clear drops valid", OUT_W'(sum_out_valid), 0);
  endtask

  task automatic t_clear_load();
    signed_mode = 1'b0;
    feed(8'h11); feed(8'h22);
    model = 16'h0033;
    cyc(1'b1, 8'h33, 1'b1, 1'b0);
    request("R8 clear+load");
  endtask

  task automatic t_hold();
    logic [OUT_W-1:0] held;
    signed_mode = 1'b0;
    do_clear();
    feed(8'h5A);
    request("R9 hold setup");
    held = sum_out;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 8'hC3, 1'b0, 1'b0);
      chk("R9 hold valid", OUT_W'(sum_out_valid), 1);
      chk("R9 hold sum", sum_out, held);
    end
    feed(8'h01);
    chk("R9 data drops valid", OUT_W'(sum_out_valid), 0);
  endtask

  task automatic t_req_with_data();
    signed_mode = 1'b0;
    do_clear();
    feed(8'h10);
    model = model + widen(8'h07, 1'b0);
    cyc(1'b1, 8'h07, 1'b0, 1'b1);
    chk("R10 valid", OUT_W'(sum_out_valid), 1);
    chk("R10 sum includes word", sum_out, 16'h0017);
    cyc(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 0; model = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0;
    signed_mode = 1'b0; clear_sum = 1'b0; sum_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unsigned();
    t_gaps();
    t_signed();
    t_wrap();
    t_clear();
    t_clear_load();
    t_hold();
    t_req_with_data();
    done = 1;
    summary();
    $finish;
  end
endmodule